// File: doc/BRIEF.md
# Memory Pattern Test Controller

This block is the supervising state machine of a memory self-test for a one-bit-wide memory. Once started, it runs a chosen subset of six test algorithms over the whole address space. Each algorithm writes every cell and then reads every cell back, comparing each bit against the value it should hold. The controller does not drive the memory strobes. It passes one operation at a time to a lower-level access sequencer over a request/acknowledge handshake, and that sequencer handles the device timing.

Software or a boot sequencer supplies a six-bit selection mask and pulses `start`. While the run is in progress, `busy` stays high. When the last selected algorithm finishes, `done` rises and holds until the next start. At that point the block reports:
- a pass/fail verdict;
- a saturating mismatch count;
- the address and algorithm number of the first mismatch.

Top module: `mem_pattern_tester`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `err_cnt`, `first_addr`, `first_pass` and `mem_req` are all 0.
- R2: A `start` pulse while idle latches `pass_mask`, clears `done`, `fail`, `err_cnt`, `first_addr` and `first_pass`, and raises `busy` on the next cycle. A `start` pulse while busy has no effect on the run's operations or results.
- R3: Each operation holds `mem_req` high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ack` is seen. `mem_rdata` is taken in the `mem_ack` cycle. `mem_req` is low for at least one cycle after each acknowledge. Exactly one operation completes per acknowledge.
- R4: Selected algorithms run in ascending mask-bit order. Within each sweep, every cell is written once, and then every cell is read once, in the same address order. Mask bits: 0 walking one, 1 walking zero, 2 checkerboard, 3 inverted checkerboard, 4 address parity ascending, 5 address parity descending.
- R5: The walking-one algorithm performs one sweep for each marker position k = 0, STRIDE, 2·STRIDE, … below 2^ADDR_W. In that sweep, cell a holds 1 only when a equals k. The walking-zero algorithm uses the same sweeps with every bit inverted.
- R6: Checkerboard data for address a is `a[ADDR_W/2] ^ a[0]` (lowest row bit XOR lowest column bit). The inverted checkerboard uses the complement.
- R7: Both parity algorithms store the XOR of all address bits at each address.
- R8: The descending parity algorithm visits addresses from 2^ADDR_W−1 down to 0, in both its write phase and its read phase. All other algorithms visit addresses from 0 upward.
- R9: Each read whose data differs from the expected bit adds one to `err_cnt`. `err_cnt` stops at 2^CNT_W−1.
- R10: `first_addr` and `first_pass` capture the address and algorithm number of the first mismatch after start, and then hold.
- R11: Unselected algorithms issue no operations. An empty mask raises `done` on the cycle after start, with `fail` low.
- R12: When the last selected algorithm finishes, `busy` drops and `done` rises in the same cycle. `fail` is 1 if and only if at least one mismatch occurred during the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| pass_mask | input | 6 | Algorithm selection, one bit per algorithm |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; holds until next start |
| fail | output | 1 | At least one mismatch in the last run |
| err_cnt | output | CNT_W | Saturating mismatch count |
| first_addr | output | ADDR_W | Address of first mismatch |
| first_pass | output | 3 | Algorithm number of first mismatch |
| mem_req | output | 1 | Operation request to the access sequencer |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Cell address of the operation |
| mem_wdata | output | 1 | Bit to write |
| mem_ack | input | 1 | Operation complete (one-cycle pulse) |
| mem_rdata | input | 1 | Read data, valid with `mem_ack` |

## Verification
The hardest situation to reach from the ports is a mismatch that appears only in a later algorithm or in a single walking sweep, so that the first-fail capture and the algorithm ordering are exercised for real. The bench's memory model can force one chosen cell to a fixed value. A table of mask and fault combinations then places the fault where only the intended algorithm and sweep can see it, including the descending pass. A fault that makes every read return one drives the counter into saturation. The bench also follows every handshake against its own model of the address and data sequence.

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester #(
  parameter int ADDR_W = 6,
  parameter int STRIDE = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [5:0]        pass_mask,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  err_cnt,
  output logic [ADDR_W-1:0] first_addr,
  output logic [2:0]        first_pass,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_rdata
);
  localparam int NP    = 6;
  localparam int PW    = 3;
  localparam int CW    = ADDR_W / 2;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] P_W1 = 3'd0, P_W0 = 3'd1, P_CB = 3'd2,
                            P_CBN = 3'd3, P_REV = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_NEXT} state_t;
  state_t st;

  logic [NP-1:0]     mask_q;
  logic [PW-1:0]     pass_q;
  logic [ADDR_W-1:0] k_q, cnt_q;
  logic              rd_q, busy_q, done_q, fail_q;
  logic [CNT_W-1:0]  err_q;
  logic [ADDR_W-1:0] faddr_q;
  logic [PW-1:0]     fpass_q;

  logic [NP-1:0]     msel;
  logic [PW:0]       lo;
  logic              nxt_ok;
  logic [PW-1:0]     nxt_pass;
  logic              exp_bit;

  assign mem_addr  = (pass_q == P_REV) ? ~cnt_q : cnt_q;
  assign mem_req   = (st == S_REQ);
  assign mem_we    = ~rd_q;
  assign mem_wdata = exp_bit;

  wire walking  = (pass_q == P_W1) || (pass_q == P_W0);
  wire last_k   = (int'(k_q) + STRIDE) >= DEPTH;
  wire last_c   = (cnt_q == {ADDR_W{1'b1}});
  wire mismatch = rd_q && (mem_rdata != exp_bit);

  always_comb begin
    case (pass_q)
      P_W1:    exp_bit = (mem_addr == k_q);
      P_W0:    exp_bit = (mem_addr != k_q);
      P_CB:    exp_bit = mem_addr[CW] ^ mem_addr[0];
      P_CBN:   exp_bit = ~(mem_addr[CW] ^ mem_addr[0]);
      default: exp_bit = ^mem_addr;
    endcase
  end

  assign msel = (st == S_IDLE) ? pass_mask : mask_q;
  assign lo   = (st == S_IDLE) ? '0 : {1'b0, pass_q} + 1'b1;

  always_comb begin
    nxt_ok   = 1'b0;
    nxt_pass = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (msel[i] && (i >= int'(lo))) begin
        nxt_ok   = 1'b1;
        nxt_pass = PW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mask_q <= '0; pass_q <= '0; k_q <= '0; cnt_q <= '0; rd_q <= 1'b0;
      busy_q <= 1'b0; done_q <= 1'b0; fail_q <= 1'b0; err_q <= '0;
      faddr_q <= '0; fpass_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mask_q <= pass_mask;
          err_q <= '0; fail_q <= 1'b0; faddr_q <= '0; fpass_q <= '0;
          cnt_q <= '0; k_q <= '0; rd_q <= 1'b0;
          if (nxt_ok) begin
            pass_q <= nxt_pass;
            busy_q <= 1'b1;
            done_q <= 1'b0;
            st     <= S_REQ;
          end else begin
            done_q <= 1'b1;
          end
        end
        S_REQ: if (mem_ack) begin
          if (mismatch) begin
            fail_q <= 1'b1;
            if (err_q != {CNT_W{1'b1}}) err_q <= err_q + 1'b1;
            if (!fail_q) begin
              faddr_q <= mem_addr;
              fpass_q <= pass_q;
            end
          end
          st <= S_NEXT;
        end
        S_NEXT: begin
          st    <= S_REQ;
          cnt_q <= cnt_q + 1'b1;
          if (last_c) begin
            if (!rd_q) rd_q <= 1'b1;
            else begin
              rd_q <= 1'b0;
              if (walking && !last_k) k_q <= k_q + ADDR_W'(STRIDE);
              else begin
                k_q <= '0;
                if (nxt_ok) pass_q <= nxt_pass;
                else begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  st     <= S_IDLE;
                end
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign fail       = fail_q;
  assign err_cnt    = err_q;
  assign first_addr = faddr_q;
  assign first_pass = fpass_q;
endmodule

// File: rtl/mem_pattern_tester_chk.sv
module mem_pattern_tester_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [CNT_W-1:0]  err_cnt,
  input logic [ADDR_W-1:0] first_addr,
  input logic [2:0]        first_pass,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wdata,
  input logic              mem_ack
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R3
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R2
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R12
  AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (err_cnt >= $past(err_cnt))); // R9
  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_cnt == {CNT_W{1'b1}}) |=> (err_cnt == {CNT_W{1'b1}})); // R9
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fail) |=> ($stable(first_addr) && $stable(first_pass))); // R10
  AST_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fail == (err_cnt != '0))); // R12
endmodule

bind mem_pattern_tester mem_pattern_tester_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
  .err_cnt(err_cnt), .first_addr(first_addr), .first_pass(first_pass),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/mem_pattern_tester_tb.sv
module mem_pattern_tester_tb;
  localparam int AW = 6, STRIDE = 16, EW = 3;
  localparam int DEPTH = 1 << AW, CW = AW / 2, EMAX = (1 << EW) - 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [5:0] pass_mask = '0;
  logic busy, done, fail, mem_req, mem_we, mem_wdata;
  logic mem_ack = 0, mem_rdata = 0;
  logic [EW-1:0] err_cnt;
  logic [AW-1:0] first_addr, mem_addr;
  logic [2:0] first_pass;

  always #2 clk = ~clk;

  mem_pattern_tester #(.ADDR_W(AW), .STRIDE(STRIDE), .CNT_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pass_mask(pass_mask),
    .busy(busy), .done(done), .fail(fail), .err_cnt(err_cnt),
    .first_addr(first_addr), .first_pass(first_pass),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int n_run = 0, n_fail = 0;
  int f_mode = 0, f_addr = 0, f_val = 0;
  bit mem [DEPTH];

  // memory model: one-cycle acknowledge, optional fault on read
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (f_mode == 2) mem_rdata <= 1'b1;
      else if (f_mode == 1 && int'(mem_addr) == f_addr) mem_rdata <= f_val[0];
      else mem_rdata <= mem[mem_addr];
    end else mem_ack <= 1'b0;
  end

  function automatic bit ebit(int p, int a, int k);
    case (p)
      0: return a == k;
      1: return a != k;
      2: return ((a >> CW) & 1) != (a & 1);
      3: return ((a >> CW) & 1) == (a & 1);
      default: return ($countones(a) % 2) == 1;
    endcase
  endfunction

  function automatic int nextsel(logic [5:0] m, int from);
    for (int i = from; i < 6; i++) if (m[i]) return i;
    return 6;
  endfunction

  // sequence monitor
  logic [5:0] mm;
  int rp, rk, rph, rc, ops, addr_err;
  int dat_err [6];
  always @(negedge clk) begin
    if (mem_req && mem_ack && rp < 6) begin
      int ea;
      ea = (rp == 5) ? DEPTH - 1 - rc : rc;
      if (int'(mem_addr) != ea || mem_we != (rph == 0)) addr_err++;
      if (mem_we && mem_wdata != ebit(rp, ea, rk)) dat_err[rp]++;
      ops++;
      rc++;
      if (rc == DEPTH) begin
        rc = 0;
        if (rph == 0) rph = 1;
        else begin
          rph = 0;
          if (rp <= 1 && rk + STRIDE < DEPTH) rk += STRIDE;
          else begin rk = 0; rp = nextsel(mm, rp + 1); end
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_run(input logic [5:0] m, input int md, fa, fv,
                         output int errs, fp, fad, nops);
    bit got = 0;
    errs = 0; fp = 0; fad = 0; nops = 0;
    for (int p = 0; p < 6; p++) if (m[p]) begin
      int nk = (p <= 1) ? (DEPTH + STRIDE - 1) / STRIDE : 1;
      for (int s = 0; s < nk; s++) begin
        nops += 2 * DEPTH;
        for (int c = 0; c < DEPTH; c++) begin
          int a = (p == 5) ? DEPTH - 1 - c : c;
          bit e = ebit(p, a, s * STRIDE);
          bit r = (md == 2) ? 1'b1 : ((md == 1 && a == fa) ? fv[0] : e);
          if (r != e) begin
            if (!got) begin got = 1; fp = p; fad = a; end
            errs++;
          end
        end
      end
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R12 watchdog done", done, 1);
  endtask

  task automatic run(input logic [5:0] m, input int md, fa, fv, input bit poke);
    int errs, fp, fad, nops, exp_cnt;
    ref_run(m, md, fa, fv, errs, fp, fad, nops);
    f_mode = md; f_addr = fa; f_val = fv;
    mm = m; rp = nextsel(m, 0); rk = 0; rph = 0; rc = 0; ops = 0; addr_err = 0;
    for (int i = 0; i < 6; i++) dat_err[i] = 0;
    @(negedge clk); start = 1; pass_mask = m;
    @(negedge clk); start = 0;
    chk(busy == 1'b1 && done == 1'b0 && err_cnt == 0, "R2 busy after start", busy, 1);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1; pass_mask = 6'h00;
      @(negedge clk); start = 0;
    end
    wait_done();
    exp_cnt = (errs > EMAX) ? EMAX : errs;
    chk(busy == 1'b0, "R12 busy low at done", busy, 0);
    chk(int'(err_cnt) == exp_cnt, "R9 error count", err_cnt, exp_cnt);
    chk(fail == (errs > 0), "R12 verdict", fail, errs > 0);
    if (errs > 0) begin
      chk(int'(first_pass) == fp, "R10 first pass", first_pass, fp);
      chk(int'(first_addr) == fad, "R10 first address", first_addr, fad);
    end
    chk(ops == nops, poke ? "R2 start ignored op count" : "R3 R11 op count", ops, nops);
    chk(addr_err == 0, m[5] ? "R8 R4 address order" : "R4 address order", addr_err, 0);
    chk(dat_err[0] + dat_err[1] == 0, "R5 walking data", dat_err[0] + dat_err[1], 0);
    chk(dat_err[2] + dat_err[3] == 0, "R6 checkerboard data", dat_err[2] + dat_err[3], 0);
    chk(dat_err[4] + dat_err[5] == 0, "R7 parity data", dat_err[4] + dat_err[5], 0);
  endtask

  // {mask[5:0], mode[1:0], addr[5:0], val}
  localparam logic [14:0] VEC [10] = '{
    {6'h3F, 2'd0, 6'd0,  1'b0},
    {6'h01, 2'd1, 6'd5,  1'b1},
    {6'h3F, 2'd1, 6'd5,  1'b1},
    {6'h0C, 2'd1, 6'd9,  1'b0},
    {6'h30, 2'd1, 6'd63, 1'b1},
    {6'h20, 2'd1, 6'd62, 1'b0},
    {6'h02, 2'd1, 6'd32, 1'b0},
    {6'h3F, 2'd2, 6'd0,  1'b0},
    {6'h14, 2'd1, 6'd0,  1'b1},
    {6'h21, 2'd1, 6'd48, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && fail == 0 && err_cnt == 0 && first_addr == 0 &&
        first_pass == 0 && mem_req == 0, "R1 reset state", busy | done | mem_req, 0);
    rst_n = 1;
    @(negedge clk);
    for (int v = 0; v < 10; v++)
      run(VEC[v][14:9], int'(VEC[v][8:7]), int'(VEC[v][6:1]), int'(VEC[v][0]), 1'b0);
    // R2 start while busy, after a failing run so clearing is visible
    run(6'h04, 1, 9, 1, 1'b1);
    // R11 empty mask
    @(negedge clk); start = 1; pass_mask = 6'h00;
    @(negedge clk); start = 0;
    chk(done == 1'b1 && busy == 1'b0, "R11 empty mask done", done, 1);
    chk(fail == 1'b0 && err_cnt == 0, "R11 empty mask verdict", fail, 0);
    repeat (4) @(negedge clk);
    chk(mem_req == 1'b0, "R11 empty mask no request", mem_req, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule